// File: doc/BRIEF.md
# LCD panel power-up sequencer

After power-on, this block brings a small LCD panel up without help from software. It first pulses the panel's reset pin through a fixed high-low-high pattern. It then asks an external command serializer for the panel's identification byte. The byte selects one of two built-in command lists: a short list for one panel revision and a long list for the other. The block walks through the selected list and hands each 9-bit word to the serializer over a valid/ready handshake. Bit 8 of each word tells the serializer whether the low byte is a command opcode or a parameter.

Each list entry carries its own pause in milliseconds, and the pause starts once the entry's last byte has been accepted. An entry with no pause moves on at once. When the list is finished, the block sends a display-on opcode, waits, sends a sleep-out opcode and raises `done_o`. A single-cycle `start_i` pulse restarts the whole sequence from the reset pulse. The millisecond base comes from a prescaler on the system clock whose division ratio is a parameter, so a bench can shorten every wait in proportion. The serial shifting, the panel's clock and any pixel path belong to other blocks.

Top module: `lcd_pwrup_seq`

## Requirements
- R1: With the reset pin present (`HAS_RST_PIN`=1), `panel_rst_o` is low while `rst_ni` is asserted and for one cycle after a reset or restart. It is then high for exactly 100·`CLKS_PER_MS` cycles, low for 40·`CLKS_PER_MS` cycles, and high for 100·`CLKS_PER_MS` cycles. After that `id_req_o` rises. `panel_rst_o` stays high while any word is offered, and no word or ID request is made during the pulse pattern.
- R2: With `HAS_RST_PIN`=0, `panel_rst_o` is constantly high and `id_req_o` is high from the first clock edge after reset release.
- R3: `id_req_o` stays high until `id_valid_i` is seen, and `id_i` is captured at that edge. An ID of 0x80 selects table A; any other value selects table B. `id_req_o` drops and the first word is offered in the next cycle.
- R4: Each entry is sent as its opcode word (`word_o[8]`=0, `word_o[7:0]`=opcode), followed by its parameter words in table order (`word_o[8]`=1, `word_o[7:0]`=parameter).
- R5: Table A has 8 entries with opcodes 0x36, 0x3A, 0xB6, 0xC5, 0xE0, 0xE1, 0xB0, 0xB4. Their parameter counts are 1, 1, 4, 2, 16, 16, 1, 1, which makes 50 words.
- R6: Table B has 22 entries and 130 words. Its first entry is opcode 0xFF with parameters 0xFF, 0x98, 0x06.
- R7: After the last word of an entry is accepted, the next word is withheld for exactly that entry's delay times `CLKS_PER_MS` cycles. In table A the delay is 20 ms after opcode 0xE1 and 100 ms after 0xB4, and 0 for every other entry. All table B delays are 0. With a delay of 0, the next word is offered in the cycle right after acceptance.
- R8: After the table, opcode word 0x29 is sent, then a 100 ms gap follows, then opcode word 0x11.
- R9: `done_o` rises in the cycle after the 0x11 word is accepted. It stays high until reset or `start_i`, and no word or ID request is made while it is high.
- R10: While `word_valid_o` is high and `word_ready_i` is low, `word_valid_o` and `word_o` hold their values.
- R11: A `start_i` pulse in any state restarts the sequence. In the next cycle `done_o`, `word_valid_o` and `id_req_o` are low, and `panel_rst_o` is low when the pin is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle pulse that restarts the sequence |
| panel_rst_o | output | 1 | Panel reset pin level |
| id_req_o | output | 1 | Request to the serializer to read the ID byte |
| id_valid_i | input | 1 | ID byte is present on id_i |
| id_i | input | 8 | Panel identification byte |
| word_valid_o | output | 1 | A command or parameter word is offered |
| word_ready_i | input | 1 | Serializer accepts the offered word |
| word_o | output | 9 | Bit 8: 0 opcode, 1 parameter; bits 7:0 the byte |
| done_o | output | 1 | Sequence complete |

## Verification
The properties assume that the serializer answers the ID request only while `id_req_o` is high, and that `start_i` is the only event allowed to withdraw an offered word. The bench answers each request once, three cycles after it appears, and changes `word_ready_i` only between clock edges. The ready pattern is either always high or an LFSR sequence, so both continuous and stalled handshakes are exercised. Restarts are issued both from the done state and in the middle of a table, after which a complete sequence is run and checked.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int unsigned MAX_PAR = 21;
  localparam int unsigned PAR_W   = $clog2(MAX_PAR + 1);
  localparam int unsigned PB_W    = MAX_PAR * 8;
  localparam int unsigned DLY_W   = 8;
  localparam int unsigned LEN_A   = 8;
  localparam int unsigned LEN_B   = 22;
  localparam int unsigned ENT_W   = $clog2(LEN_B);

  localparam logic [7:0] ID_SEL_A   = 8'h80;
  localparam logic [7:0] OP_DISP_ON = 8'h29;
  localparam logic [7:0] OP_SLP_OUT = 8'h11;

  typedef struct packed {
    logic [7:0]       op;
    logic [PAR_W-1:0] npar;
    logic [DLY_W-1:0] dly;
    logic [PB_W-1:0]  prm;   // first parameter in the highest used byte
  } ent_t;

  typedef enum logic [3:0] {
    S_BOOT, S_RH1, S_RLO, S_RH2, S_ID, S_CMD, S_GAP,
    S_DON, S_DGAP, S_SLP, S_DONE
  } st_e;

  function automatic ent_t mk(input logic [7:0] op, input int n, input int d,
                              input logic [PB_W-1:0] p);
    ent_t e;
    e.op   = op;
    e.npar = PAR_W'(n);
    e.dly  = DLY_W'(d);
    e.prm  = p;
    return e;
  endfunction

  function automatic ent_t ent_a(input int idx);
    ent_t e;
    case (idx)
      0:       e = mk(8'h36, 1, 0, PB_W'(8'h08));
      1:       e = mk(8'h3A, 1, 0, PB_W'(8'h66));
      2:       e = mk(8'hB6, 4, 0, PB_W'(32'h22E2FF04));
      3:       e = mk(8'hC5, 2, 0, PB_W'(16'h006A));
      4:       e = mk(8'hE0, 16, 0, PB_W'(128'h00070D10_13190F0C_05080613_0F30201F));
      5:       e = mk(8'hE1, 16, 20, PB_W'(128'h1F20300F_13060805_0C0F1913_100D0700));
      6:       e = mk(8'hB0, 1, 0, PB_W'(8'h01));
      7:       e = mk(8'hB4, 1, 100, PB_W'(8'h02));
      default: e = '0;
    endcase
    return e;
  endfunction

  function automatic ent_t ent_b(input int idx);
    ent_t e;
    case (idx)
      0:       e = mk(8'hFF, 3, 0, PB_W'(24'hFF9806));
      1:       e = mk(8'hBA, 1, 0, PB_W'(8'h60));
      2:       e = mk(8'hBC, 21, 0,
                      PB_W'(168'h01106174_01011B12_71000000_010105_00FFF201_0040));
      3:       e = mk(8'hBD, 8, 0, PB_W'(64'h01234567_01234567));
      4:       e = mk(8'hBE, 9, 0, PB_W'(72'h01_2222BADC_26282222));
      5:       e = mk(8'hC7, 1, 0, PB_W'(8'h74));
      6:       e = mk(8'hED, 3, 0, PB_W'(24'h7F0F00));
      7:       e = mk(8'hC0, 3, 0, PB_W'(24'h030B00));
      8:       e = mk(8'hFC, 1, 0, PB_W'(8'h08));
      9:       e = mk(8'hB6, 1, 0, PB_W'(8'hA0));
      10:      e = mk(8'hDF, 6, 0, PB_W'(48'h0000_00000020));
      11:      e = mk(8'hF3, 1, 0, PB_W'(8'h74));
      12:      e = mk(8'hB4, 3, 0, PB_W'(24'h000000));
      13:      e = mk(8'hF7, 1, 0, PB_W'(8'h82));
      14:      e = mk(8'hB1, 3, 0, PB_W'(24'h001313));
      15:      e = mk(8'hF2, 4, 0, PB_W'(32'h80054028));
      16:      e = mk(8'hC1, 4, 0, PB_W'(32'h17757920));
      17:      e = mk(8'h36, 1, 0, PB_W'(8'h00));
      18:      e = mk(8'h3A, 1, 0, PB_W'(8'h66));
      19:      e = mk(8'hE0, 16, 0, PB_W'(128'h00030B0C_0E08C504_080C1311_11140C10));
      20:      e = mk(8'hE1, 16, 0, PB_W'(128'h000D110C_0C047603_080B1610_0D160A00));
      21:      e = mk(8'h35, 1, 0, PB_W'(8'h00));
      default: e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/lcd_ms_tick.sv
module lcd_ms_tick #(
  parameter int unsigned CLKS_PER_MS = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned PRE_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(CLKS_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick_o = en_i && (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (en_i)   pre_q <= tick_o ? '0 : pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
  parameter int unsigned CLKS_PER_MS = 100000,
  parameter int unsigned MS_W        = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            expire_o
);
  logic [MS_W-1:0] cnt_q;
  logic            tick;

  lcd_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_i),
    .en_i   (cnt_q != '0),
    .tick_o (tick)
  );

  // pulses in the cycle whose closing edge ends the wait
  assign expire_o = tick && (cnt_q == MS_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= ms_i;
    else if (tick)   cnt_q <= cnt_q - MS_W'(1);
  end
endmodule

// File: rtl/lcd_cmd_rom.sv
module lcd_cmd_rom
  import lcd_seq_pkg::*;
(
  input  logic             tbl_i,   // 0: table A, 1: table B
  input  logic [ENT_W-1:0] ent_i,
  input  logic [PAR_W-1:0] sel_i,   // parameter index within entry
  output logic [7:0]       op_o,
  output logic [PAR_W-1:0] npar_o,
  output logic [DLY_W-1:0] dly_o,
  output logic [7:0]       par_o,
  output logic             last_o
);
  ent_t ent;
  int   pos;

  always_comb begin
    ent    = tbl_i ? ent_b(int'(ent_i)) : ent_a(int'(ent_i));
    last_o = tbl_i ? (int'(ent_i) == LEN_B - 1) : (int'(ent_i) == LEN_A - 1);
  end

  assign op_o   = ent.op;
  assign npar_o = ent.npar;
  assign dly_o  = ent.dly;

  always_comb begin
    pos = int'(ent.npar) - 1 - int'(sel_i);
    if (pos < 0) pos = 0;
    par_o = ent.prm[pos*8 +: 8];
  end
endmodule

// File: rtl/lcd_pwrup_seq.sv
module lcd_pwrup_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned CLKS_PER_MS = 100000,
  parameter bit          HAS_RST_PIN = 1'b1,
  parameter int unsigned RST_HI_MS   = 100,
  parameter int unsigned RST_LO_MS   = 40,
  parameter int unsigned TAIL_MS     = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       panel_rst_o,
  output logic       id_req_o,
  input  logic       id_valid_i,
  input  logic [7:0] id_i,
  output logic       word_valid_o,
  input  logic       word_ready_i,
  output logic [8:0] word_o,
  output logic       done_o
);
  st_e              st_q, st_d;
  logic             tbl_q, tbl_d;
  logic [ENT_W-1:0] ent_q, ent_d;
  logic [PAR_W-1:0] idx_q, idx_d;   // 0: opcode, k: parameter k-1

  logic             ld;
  logic [DLY_W-1:0] ld_ms;
  logic             expire;
  logic             adv;

  logic [7:0]       rom_op, rom_par;
  logic [PAR_W-1:0] rom_npar;
  logic [DLY_W-1:0] rom_dly;
  logic             rom_last;

  lcd_cmd_rom i_rom (
    .tbl_i  (tbl_q),
    .ent_i  (ent_q),
    .sel_i  (idx_q - PAR_W'(1)),
    .op_o   (rom_op),
    .npar_o (rom_npar),
    .dly_o  (rom_dly),
    .par_o  (rom_par),
    .last_o (rom_last)
  );

  lcd_ms_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MS_W(DLY_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (ld),
    .ms_i     (ld_ms),
    .expire_o (expire)
  );

  always_comb begin
    st_d  = st_q;
    tbl_d = tbl_q;
    ent_d = ent_q;
    idx_d = idx_q;
    ld    = 1'b0;
    ld_ms = '0;
    adv   = 1'b0;
    unique case (st_q)
      S_BOOT: begin
        if (HAS_RST_PIN) begin
          ld = 1'b1; ld_ms = DLY_W'(RST_HI_MS); st_d = S_RH1;
        end else begin
          st_d = S_ID;
        end
      end
      S_RH1: if (expire) begin ld = 1'b1; ld_ms = DLY_W'(RST_LO_MS); st_d = S_RLO; end
      S_RLO: if (expire) begin ld = 1'b1; ld_ms = DLY_W'(RST_HI_MS); st_d = S_RH2; end
      S_RH2: if (expire) st_d = S_ID;
      S_ID: begin
        if (id_valid_i) begin
          tbl_d = (id_i != ID_SEL_A);
          ent_d = '0;
          idx_d = '0;
          st_d  = S_CMD;
        end
      end
      S_CMD: begin
        if (word_ready_i) begin
          if (idx_q == rom_npar) begin
            if (rom_dly != '0) begin
              ld = 1'b1; ld_ms = rom_dly; st_d = S_GAP;
            end else begin
              adv = 1'b1;
            end
          end else begin
            idx_d = idx_q + PAR_W'(1);
          end
        end
      end
      S_GAP:  if (expire) adv = 1'b1;
      S_DON:  if (word_ready_i) begin ld = 1'b1; ld_ms = DLY_W'(TAIL_MS); st_d = S_DGAP; end
      S_DGAP: if (expire) st_d = S_SLP;
      S_SLP:  if (word_ready_i) st_d = S_DONE;
      S_DONE: st_d = S_DONE;
      default: st_d = S_BOOT;
    endcase
    if (adv) begin
      if (rom_last) begin
        st_d = S_DON;
      end else begin
        ent_d = ent_q + ENT_W'(1);
        idx_d = '0;
        st_d  = S_CMD;
      end
    end
    if (start_i) st_d = S_BOOT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_BOOT;
      tbl_q <= 1'b0;
      ent_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      tbl_q <= tbl_d;
      ent_q <= ent_d;
      idx_q <= idx_d;
    end
  end

  always_comb begin
    unique case (st_q)
      S_CMD:   word_o = (idx_q == '0) ? {1'b0, rom_op} : {1'b1, rom_par};
      S_DON:   word_o = {1'b0, OP_DISP_ON};
      S_SLP:   word_o = {1'b0, OP_SLP_OUT};
      default: word_o = '0;
    endcase
  end

  assign word_valid_o = (st_q == S_CMD) || (st_q == S_DON) || (st_q == S_SLP);
  assign id_req_o     = (st_q == S_ID);
  assign done_o       = (st_q == S_DONE);

  generate
    if (HAS_RST_PIN) begin : g_pin
      assign panel_rst_o = !((st_q == S_BOOT) || (st_q == S_RLO));
    end else begin : g_no_pin
      assign panel_rst_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/lcd_pwrup_seq_chk.sv
module lcd_pwrup_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       panel_rst_o,
  input logic       id_req_o,
  input logic       id_valid_i,
  input logic       word_valid_o,
  input logic       word_ready_i,
  input logic [8:0] word_o,
  input logic       done_o
);
  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i && !start_i |=> word_valid_o && $stable(word_o)); // R10

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o); // R9

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !word_valid_o && !id_req_o); // R9

  AST_PIN_HIGH_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o || id_req_o |-> panel_rst_o); // R1

  AST_ID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_req_o && !id_valid_i && !start_i |=> id_req_o); // R3

  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o && !word_valid_o && !id_req_o); // R11
endmodule

bind lcd_pwrup_seq lcd_pwrup_seq_chk i_lcd_pwrup_seq_chk (.*);

// File: tb/test_lcd_pwrup_seq.sv
module test_lcd_pwrup_seq;
  localparam int T = 3;

  logic       clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic       word_ready_i = 1'b0, id_valid_i = 1'b0;
  logic [7:0] id_i = 8'h00;
  logic [8:0] word_o;
  logic       word_valid_o, id_req_o, done_o, panel_rst_o;
  logic [8:0] nr_word;
  logic       nr_valid, nr_idreq, nr_done, nr_pin;

  int         nchk = 0, nerr = 0;
  bit         stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [8:0] words [0:255];
  int         gaps  [0:255];

  always #5 clk_i = ~clk_i;

  lcd_pwrup_seq #(.CLKS_PER_MS(T), .HAS_RST_PIN(1'b1)) i_lcd_pwrup_seq (
    .clk_i, .rst_ni, .start_i, .panel_rst_o, .id_req_o, .id_valid_i, .id_i,
    .word_valid_o, .word_ready_i, .word_o, .done_o
  );

  lcd_pwrup_seq #(.CLKS_PER_MS(T), .HAS_RST_PIN(1'b0)) i_lcd_pwrup_seq_norst (
    .clk_i, .rst_ni, .start_i(1'b0), .panel_rst_o(nr_pin), .id_req_o(nr_idreq),
    .id_valid_i(1'b0), .id_i(8'h00), .word_valid_o(nr_valid), .word_ready_i(1'b0),
    .word_o(nr_word), .done_o(nr_done)
  );

  initial forever begin
    @(posedge clk_i); #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    word_ready_i = stall_en ? lfsr[0] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o === 1'b0 && panel_rst_o === 1'b0 && word_valid_o === 1'b0 && id_req_o === 1'b0,
        "R11", "state after restart", {done_o, panel_rst_o, word_valid_o, id_req_o}, 0);
  endtask

  task automatic run(input logic [7:0] id, input int abort_at);
    logic [7:0] opa [8] = '{8'h36, 8'h3A, 8'hB6, 8'hC5, 8'hE0, 8'hE1, 8'hB0, 8'hB4};
    int         npa [8] = '{1, 1, 4, 2, 16, 16, 1, 1};
    int         dla [8] = '{0, 0, 0, 0, 0, 20, 0, 100};
    int hi, lo, nw, gap, pos, bad, since, ent, eg;
    bit stl, is_a;
    logic [8:0] sw;
    is_a = (id == 8'h80);
    bad = 0;
    while (panel_rst_o !== 1'b1) @(negedge clk_i);
    hi = 0;
    while (panel_rst_o === 1'b1) begin
      hi++; if (word_valid_o || id_req_o) bad++; @(negedge clk_i);
    end
    chk(hi == 100*T, "R1", "first high phase", hi, 100*T);
    lo = 0;
    while (panel_rst_o !== 1'b1) begin
      lo++; if (word_valid_o || id_req_o) bad++; @(negedge clk_i);
    end
    chk(lo == 40*T, "R1", "low phase", lo, 40*T);
    hi = 0;
    while (id_req_o !== 1'b1) begin
      hi++; if (word_valid_o || panel_rst_o !== 1'b1) bad++; @(negedge clk_i);
    end
    chk(hi == 100*T, "R1", "second high phase", hi, 100*T);
    chk(bad == 0, "R1", "quiet during reset pattern", bad, 0);
    repeat (3) begin
      @(negedge clk_i);
      chk(id_req_o === 1'b1 && word_valid_o === 1'b0, "R3", "request held", id_req_o, 1);
    end
    id_i = id; id_valid_i = 1'b1;
    @(negedge clk_i);
    id_valid_i = 1'b0;
    chk(id_req_o === 1'b0 && word_valid_o === 1'b1, "R3", "request drops, first word offered",
        {id_req_o, word_valid_o}, 1);
    nw = 0; gap = 0; stl = 1'b0; sw = '0; since = 0;
    while (done_o !== 1'b1 && nw < 250) begin
      if (stl) chk(word_valid_o === 1'b1 && word_o === sw, "R10", "word held while stalled",
                   word_o, sw);
      stl = 1'b0;
      if (word_valid_o === 1'b1) begin
        if (word_ready_i) begin
          words[nw] = word_o; gaps[nw] = gap; nw++; gap = 0; since = 0;
          if (nw == abort_at) begin
            pulse_start();
            return;
          end
        end else begin
          stl = 1'b1; sw = word_o;
        end
      end else begin
        gap++;
      end
      @(negedge clk_i);
      since++;
    end
    chk(since == 1, "R9", "done one cycle after sleep-out", since, 1);
    chk(nw == (is_a ? 52 : 132), is_a ? "R5" : "R6", "word count", nw, is_a ? 52 : 132);
    if (is_a) begin
      pos = 0;
      for (int e = 0; e < 8; e++) begin
        eg = (e == 0) ? 0 : dla[e-1] * T;
        chk(words[pos] == {1'b0, opa[e]}, "R5", "opcode", words[pos], {1'b0, opa[e]});
        chk(gaps[pos] == eg, "R7", "wait before entry", gaps[pos], eg);
        for (int p = 1; p <= npa[e]; p++) begin
          chk(words[pos+p][8] == 1'b1, "R4", "parameter flag", words[pos+p], 9'h100);
          chk(gaps[pos+p] == 0, "R7", "no wait inside entry", gaps[pos+p], 0);
        end
        pos += 1 + npa[e];
      end
    end else begin
      ent = 0; bad = 0;
      for (int k = 0; k < 130; k++) begin
        if (!words[k][8]) ent++;
        if (gaps[k] != 0) bad++;
      end
      chk(ent == 22, "R6", "entry count", ent, 22);
      chk(bad == 0, "R7", "zero-delay entries back to back", bad, 0);
      chk(words[0] == 9'h0FF, "R6", "first opcode", words[0], 9'h0FF);
      chk(words[1] == 9'h1FF, "R4", "first parameter", words[1], 9'h1FF);
      chk(words[2] == 9'h198, "R6", "second parameter", words[2], 9'h198);
      chk(words[3] == 9'h106, "R6", "third parameter", words[3], 9'h106);
      pos = 130;
    end
    chk(words[pos] == 9'h029, "R8", "display-on word", words[pos], 9'h029);
    chk(gaps[pos] == (is_a ? 100*T : 0), "R7", "wait after last entry", gaps[pos],
        is_a ? 100*T : 0);
    chk(words[pos+1] == 9'h011, "R8", "sleep-out word", words[pos+1], 9'h011);
    chk(gaps[pos+1] == 100*T, "R8", "gap before sleep-out", gaps[pos+1], 100*T);
    bad = 0;
    repeat (30) begin
      @(negedge clk_i);
      if (!(done_o === 1'b1 && word_valid_o === 1'b0 && id_req_o === 1'b0)) bad++;
    end
    chk(bad == 0, "R9", "done held and quiet", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    nchk++; nerr++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(panel_rst_o === 1'b0 && done_o === 1'b0 && word_valid_o === 1'b0 && id_req_o === 1'b0,
        "R1", "reset state", {panel_rst_o, done_o, word_valid_o, id_req_o}, 0);
    rst_ni = 1'b1;
    fork
      begin
        @(negedge clk_i);
        chk(nr_idreq === 1'b1, "R2", "request right after reset without pin", nr_idreq, 1);
        repeat (20) begin
          chk(nr_pin === 1'b1 && nr_valid === 1'b0, "R2", "pin high, no word",
              {nr_pin, nr_valid}, 2);
          @(negedge clk_i);
        end
      end
      run(8'h80, 0);
    join
    stall_en = 1'b1; pulse_start(); run(8'h00, 0);
    pulse_start(); run(8'h81, 0);
    stall_en = 1'b0; pulse_start(); run(8'h7F, 40);
    run(8'hFF, 0);
    stall_en = 1'b1; pulse_start(); run(8'h80, 45);
    run(8'h80, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule